// File: doc/BRIEF.md
# Local Interrupt Controller Timer

This block is the programmable countdown timer that sits beside a processor core's local interrupt controller. Software programs three registers: a reload value, a prescale selection and a timer entry. The timer entry holds an interrupt vector, a mask flag and a repeat-mode flag. From the moment the reload value is written, the timer counts prescaled ticks. A power-of-two divider on the system clock produces those ticks. A fourth register, which cannot be written, returns the live count.

In one-shot mode the count runs down to zero and fires once. In periodic mode each period lasts the reload value plus one ticks, and the timer fires at the end of every period. Each expiry is an outbound event: a single-cycle `irq_valid` pulse that carries the programmed vector on `irq_vector`. This event stream has no ready input and no back-pressure. The consumer must take the vector in the cycle that `irq_valid` is high, because the pulse is neither held nor queued. The register port is a plain write strobe, with a combinational read mux beside it.

Top module: `local_irq_timer`

## Requirements
- R1: After reset the timer entry reads 0x0001_0000 (masked, one-shot, vector 0). The prescale register, the reload value and the live count all read 0, and `irq_valid` is low.
- R2: The register selects are as follows. Select 0 is the 32-bit reload value. Select 1 is the prescale register, which keeps bits 3, 1 and 0 and reads 0 in every other bit. Select 2 is the timer entry: vector in bits 7:0, mask in bit 16, periodic in bit 17, all other bits 0. Select 3 is the live count, which is read-only; writes to it change nothing. `rd_data` follows `rd_sel` in the same cycle.
- R3: The prescale code is {bit3, bit1, bit0}. Code 3'b111 divides by 1. Any other code c divides by 2^(c+1), so the divisors run from 2 up to 128. The elapsed tick count d is the number of clock edges since the reload write edge, divided by the divisor and rounded down.
- R4: Writing the reload value makes that clock edge the new load point. Counting and prescaling restart from that edge, and any pending expiry of the earlier load is dropped.
- R5: In one-shot mode the live count reads reload − d while d is below the reload value, and 0 from then on.
- R6: In one-shot mode there is exactly one expiry, at d = reload + 1, and none follows until the next reload write. A reload value of 0 never fires.
- R7: In periodic mode the live count reads reload − (d mod (reload + 1)).
- R8: In periodic mode an expiry occurs each time d reaches a whole multiple of reload + 1. A reload value of 0 never fires.
- R9: The timer fires no interrupt while the mask bit is set. The mask is sampled at the expiry edge. Counting continues while masked, so the live count stays correct.
- R10: For an expiry at clock edge E, `irq_valid` is high for exactly the one cycle after E, and `irq_vector` equals the entry's bits 7:0 as they stood at E.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select for writes |
| wr_data | input | 32 | Write data |
| rd_sel | input | 2 | Register select for reads |
| rd_data | output | 32 | Combinational read data |
| irq_valid | output | 1 | One-cycle expiry event |
| irq_vector | output | 8 | Vector carried with the expiry event |

## Verification
The assertions check on every cycle that a masked timer never raises an event and that each event lasts one cycle with the vector of its expiry edge. They also check that a one-shot count parked at zero stays there, that a periodic wrap reloads the programmed value, that a write to the read-only count leaves the reload value alone, and that prescaled ticks never come back to back. Only the bench scenarios can show that expiries land on the exact edge given by reload and divisor, that the readback follows the modulo and clamp formulas over time, and that rewriting or zeroing the reload cancels a pending expiry.

// File: rtl/lit_pkg.sv
package lit_pkg;

  localparam int DATA_W   = 32;
  localparam int VEC_W    = 8;
  localparam int DIV_W    = 4;
  localparam int SHIFT_W  = 3;
  localparam int PRE_W    = (1 << SHIFT_W) - 1;
  localparam int MASK_BIT = 16;
  localparam int MODE_BIT = 17;

  typedef enum logic [1:0] {
    SEL_RELOAD = 2'd0,
    SEL_PRESC  = 2'd1,
    SEL_ENTRY  = 2'd2,
    SEL_LIVE   = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic             periodic;
    logic             masked;
    logic [VEC_W-1:0] vector;
  } entry_t;

  // Prescale code {b3,b1,b0}: 3'b111 is divide-by-1, otherwise shift = code + 1.
  function automatic logic [SHIFT_W-1:0] code_to_shift(input logic [DIV_W-1:0] dc);
    logic [2:0] c;
    c = {dc[3], dc[1:0]};
    if (c == 3'b111) return '0;
    return SHIFT_W'(c + 3'd1);
  endfunction

endpackage

// File: rtl/lit_regs.sv
module lit_regs
  import lit_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        rd_sel,
  input  logic [CNT_W-1:0]  live_i,
  output logic [CNT_W-1:0]  reload_o,
  output logic [CNT_W-1:0]  load_val_o,
  output logic              load_o,
  output logic [SHIFT_W-1:0] shift_o,
  output entry_t            entry_o,
  output logic [DATA_W-1:0] rd_data
);

  logic [CNT_W-1:0] reload_q;
  logic [DIV_W-1:0] presc_q;
  entry_t           entry_q;
  reg_sel_e         wsel;
  reg_sel_e         rsel;

  assign wsel       = reg_sel_e'(wr_sel);
  assign rsel       = reg_sel_e'(rd_sel);
  assign load_o     = wr_en && (wsel == SEL_RELOAD);
  assign load_val_o = wr_data[CNT_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_q         <= '0;
      presc_q          <= '0;
      entry_q.periodic <= 1'b0;
      entry_q.masked   <= 1'b1;
      entry_q.vector   <= '0;
    end else if (wr_en) begin
      unique case (wsel)
        SEL_RELOAD: reload_q <= wr_data[CNT_W-1:0];
        SEL_PRESC:  presc_q  <= {wr_data[3], 1'b0, wr_data[1:0]};
        SEL_ENTRY: begin
          entry_q.vector   <= wr_data[VEC_W-1:0];
          entry_q.masked   <= wr_data[MASK_BIT];
          entry_q.periodic <= wr_data[MODE_BIT];
        end
        SEL_LIVE: ;
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_data = '0;
    unique case (rsel)
      SEL_RELOAD: rd_data = DATA_W'(reload_q);
      SEL_PRESC:  rd_data[DIV_W-1:0] = presc_q;
      SEL_ENTRY: begin
        rd_data[VEC_W-1:0] = entry_q.vector;
        rd_data[MASK_BIT]  = entry_q.masked;
        rd_data[MODE_BIT]  = entry_q.periodic;
      end
      SEL_LIVE:   rd_data = DATA_W'(live_i);
      default:    rd_data = '0;
    endcase
  end

  assign reload_o = reload_q;
  assign shift_o  = code_to_shift(presc_q);
  assign entry_o  = entry_q;

  AST_LIVE_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wsel == SEL_LIVE) |=> $stable(reload_q)); // R2

endmodule

// File: rtl/lit_prescaler.sv
module lit_prescaler
  import lit_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               restart_i,
  input  logic [SHIFT_W-1:0] shift_i,
  output logic               tick_o
);

  logic [PRE_W-1:0] phase_q;
  logic [PRE_W-1:0] sel_mask;

  // Low-bit mask of the phase counter for the selected divisor.
  always_comb begin
    sel_mask = '0;
    for (int i = 0; i < PRE_W; i++) begin
      if (i < int'(shift_i)) sel_mask[i] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         phase_q <= '0;
    else if (restart_i) phase_q <= '0;
    else                phase_q <= phase_q + 1'b1;
  end

  assign tick_o = !restart_i && ((phase_q & sel_mask) == sel_mask);

  AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && shift_i != '0) |=> (!tick_o || shift_i != $past(shift_i))); // R3

endmodule

// File: rtl/lit_counter.sv
module lit_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic [CNT_W-1:0] reload_i,
  input  logic             periodic_i,
  input  logic             tick_i,
  output logic [CNT_W-1:0] live_o,
  output logic             fire_o
);

  logic [CNT_W-1:0] live_q;
  logic             armed_q;
  logic             at_zero;

  assign at_zero = (live_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q  <= '0;
      armed_q <= 1'b0;
    end else if (load_i) begin
      live_q  <= load_val_i;
      armed_q <= (load_val_i != '0);
    end else if (tick_i) begin
      if (!at_zero)        live_q  <= live_q - 1'b1;
      else if (periodic_i) live_q  <= reload_i;
      else                 armed_q <= 1'b0;
    end
  end

  assign fire_o = tick_i && !load_i && at_zero &&
                  (periodic_i ? (reload_i != '0) : armed_q);
  assign live_o = live_q;

  AST_LIVE_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    live_q <= reload_i); // R7

  AST_ONESHOT_PARKS: assert property (@(posedge clk) disable iff (!rst_n)
    (!periodic_i && at_zero && !load_i) |=> (live_q == '0)); // R5

  AST_PERIOD_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (periodic_i && tick_i && at_zero && !load_i) |=> (live_q == $past(reload_i))); // R8

endmodule

// File: rtl/local_irq_timer.sv
module local_irq_timer
  import lit_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        rd_sel,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq_valid,
  output logic [VEC_W-1:0]  irq_vector
);

  logic [CNT_W-1:0]   reload;
  logic [CNT_W-1:0]   load_val;
  logic [CNT_W-1:0]   live;
  logic               load;
  logic [SHIFT_W-1:0] shift;
  entry_t             entry;
  logic               tick;
  logic               fire;
  logic               irq_q;
  logic [VEC_W-1:0]   vec_q;

  lit_regs #(.CNT_W(CNT_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_sel     (wr_sel),
    .wr_data    (wr_data),
    .rd_sel     (rd_sel),
    .live_i     (live),
    .reload_o   (reload),
    .load_val_o (load_val),
    .load_o     (load),
    .shift_o    (shift),
    .entry_o    (entry),
    .rd_data    (rd_data)
  );

  lit_prescaler u_presc (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart_i (load),
    .shift_i   (shift),
    .tick_o    (tick)
  );

  lit_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (load),
    .load_val_i (load_val),
    .reload_i   (reload),
    .periodic_i (entry.periodic),
    .tick_i     (tick),
    .live_o     (live),
    .fire_o     (fire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
      vec_q <= '0;
    end else begin
      irq_q <= fire && !entry.masked;
      if (fire && !entry.masked) vec_q <= entry.vector;
    end
  end

  assign irq_valid  = irq_q;
  assign irq_vector = vec_q;

  AST_MASK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> !$past(entry.masked)); // R9

  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |=> !irq_valid); // R10

  AST_IRQ_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> (irq_vector == $past(entry.vector))); // R10

endmodule

// File: tb/local_irq_timer_bench.sv
module local_irq_timer_bench;
  import lit_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic [1:0]  rd_sel = '0;
  logic [31:0] rd_data;
  logic        irq_valid;
  logic [7:0]  irq_vector;

  always #4 clk = ~clk;

  local_irq_timer u_local_irq_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .irq_valid(irq_valid), .irq_vector(irq_vector)
  );

  int unsigned edge_n = 0;
  always @(posedge clk) edge_n <= edge_n + 1;

  int total = 0;
  int bad = 0;

  typedef struct {
    int unsigned at;
    logic [7:0]  vec;
    string       req;
  } exp_t;
  exp_t sbq[$];

  int unsigned ld_edge = 0;
  longint      ld_init = 0;
  int          ld_shift = 0;
  bit          ld_per = 0;
  logic [7:0]  ld_vec = '0;

  // Monitor: every event is popped from the scoreboard and compared.
  always @(negedge clk) begin : mon
    exp_t e;
    if (rst_n && irq_valid) begin
      total++;
      if (sbq.size() == 0) begin
        bad++;
        $display("FAIL R6/R8/R9 unexpected event at edge %0d vector %02h, expected none",
                 edge_n, irq_vector);
      end else begin
        e = sbq.pop_front();
        if (e.at != edge_n || e.vec != irq_vector) begin
          bad++;
          $display("FAIL %s event edge=%0d vec=%02h expected edge=%0d vec=%02h",
                   e.req, edge_n, irq_vector, e.at, e.vec);
        end
      end
    end
  end

  always @(negedge clk) begin
    if (edge_n > 100000) begin
      bad++;
      $display("FAIL watchdog expired at edge %0d, expected completion", edge_n);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string req, input string what, input longint got, input longint exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, got, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
    if (sel == 2'd0) begin
      ld_edge = edge_n;
      ld_init = longint'(data);
    end
  endtask

  task automatic rd(input logic [1:0] sel, output logic [31:0] v);
    rd_sel = sel;
    #1;
    v = rd_data;
  endtask

  function automatic longint exp_live(input int unsigned k);
    longint d;
    d = longint'(k) >>> ld_shift;
    if (ld_per) return ld_init - (d % (ld_init + 1));
    if (d >= ld_init) return 0;
    return ld_init - d;
  endfunction

  task automatic chk_live(input string req);
    logic [31:0] v;
    rd(2'd3, v);
    chk(req, "live count", longint'(v), exp_live(edge_n - ld_edge));
  endtask

  // Driver: stop the old load, program prescale and entry, then reload.
  task automatic start(input bit per, input bit msk, input logic [7:0] vec,
                       input logic [3:0] dcode, input logic [31:0] init);
    logic [2:0] c;
    wr(2'd0, 32'd0);
    wr(2'd1, {28'd0, dcode});
    wr(2'd2, {14'd0, per, msk, 8'd0, vec});
    c = {dcode[3], dcode[1:0]};
    ld_shift = (c == 3'b111) ? 0 : int'(c) + 1;
    ld_per = per;
    ld_vec = vec;
    wr(2'd0, init);
  endtask

  task automatic expect_irq(input string req, input int n);
    exp_t e;
    e.at  = ld_edge + ((n * (int'(ld_init) + 1)) << ld_shift);
    e.vec = ld_vec;
    e.req = req;
    sbq.push_back(e);
  endtask

  initial begin
    logic [31:0] v;
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R1 reset state
    rd(2'd2, v); chk("R1", "entry", v, 32'h0001_0000);
    rd(2'd1, v); chk("R1", "prescale", v, 0);
    rd(2'd0, v); chk("R1", "reload", v, 0);
    rd(2'd3, v); chk("R1", "live", v, 0);
    chk("R1", "irq_valid", irq_valid, 0);

    // R2 field masking on readback
    wr(2'd1, 32'hFFFF_FFFF); rd(2'd1, v); chk("R2", "prescale bits", v, 32'hB);
    wr(2'd2, 32'hFFFF_FFFF); rd(2'd2, v); chk("R2", "entry bits", v, 32'h0003_00FF);
    wr(2'd2, 32'h0001_0000);

    // R5 R6 one-shot, divide by 1
    start(1'b0, 1'b0, 8'h41, 4'b1011, 32'd5);
    expect_irq("R6", 1);
    idle(2); chk_live("R5");
    idle(3); chk_live("R5");
    idle(4); chk_live("R5");
    idle(20); chk_live("R6");

    // R3 divide by 2 and by 128
    start(1'b0, 1'b0, 8'h17, 4'b0000, 32'd3);
    expect_irq("R3", 1);
    idle(3); chk_live("R3");
    idle(4); chk_live("R3");
    idle(10);
    start(1'b0, 1'b0, 8'h99, 4'b1010, 32'd2);
    expect_irq("R3", 1);
    idle(127); chk_live("R3");
    idle(1);   chk_live("R3");
    idle(172); chk_live("R3");
    idle(100);

    // R2 write to live count ignored
    start(1'b0, 1'b0, 8'h63, 4'b1011, 32'd20);
    expect_irq("R2", 1);
    idle(4);
    wr(2'd3, 32'h0000_1234);
    chk_live("R2");
    rd(2'd0, v); chk("R2", "reload after live write", v, 20);
    idle(25);

    // R7 R8 R9 periodic, then masked mid-run
    start(1'b1, 1'b0, 8'h22, 4'b1011, 32'd3);
    for (int n = 1; n <= 4; n++) expect_irq("R8", n);
    idle(2); chk_live("R7");
    idle(5); chk_live("R7");
    idle(10);
    wr(2'd2, {14'd0, 1'b1, 1'b1, 8'd0, 8'h22});
    idle(9); chk_live("R9");
    idle(14); chk_live("R9");

    // R8 periodic with zero reload never fires
    start(1'b1, 1'b0, 8'h33, 4'b1011, 32'd0);
    idle(40); chk_live("R8");

    // R9 masked one-shot keeps counting, no event
    start(1'b0, 1'b1, 8'h44, 4'b1011, 32'd6);
    idle(3); chk_live("R9");
    idle(12); chk_live("R9");

    // R6 zero reload in one-shot stops a pending expiry
    start(1'b0, 1'b0, 8'h55, 4'b1011, 32'd10);
    idle(3);
    wr(2'd0, 32'd0);
    idle(30); chk_live("R6");

    // R4 rewriting the reload restarts the count
    start(1'b0, 1'b0, 8'h66, 4'b1011, 32'd6);
    idle(3);
    wr(2'd0, 32'd6);
    expect_irq("R4", 1);
    idle(4); chk_live("R4");
    idle(10);

    chk("R6", "scoreboard leftovers", sbq.size(), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule